// File: doc/BRIEF.md
# Dynamic Bus-Sizing Lane Steerer

The steerer accepts one access from a 32-bit internal bus (byte, halfword or word, a byte offset, a direction, write data) and carries it out against an external memory data bus. The target device on that bus is 8, 16 or 32 bits wide, and the external bus itself is either full width or half width. When the target is narrower than the access, the access is split into an ordered series of narrow transfers. The steerer presents each transfer in turn with its byte offset, its routed write lanes and its active-low lane write strobes. It steps to the next transfer only when the external side signals ready.

On reads, the lanes returned by each transfer are placed into their positions in the internal word. The full word is then presented together with a one-cycle completion pulse. A static input selects little- or big-endian numbering. In big-endian mode, memory byte offset b corresponds to internal byte lane 3-b. The routing rule is the same for every combination. Memory byte b of the access goes to external lane b modulo the target width in bytes, and it comes from internal lane b (little-endian) or 3-b (big-endian).

A configuration the hardware cannot perform is answered with an error completion and no external activity. The illegal cases are a full-width target on a half-width bus, the reserved target code, and the reserved size code.

Top module: `bus_sizer`

## Requirements
- R1: An accepted request is illegal when req_size_i is 3, when tgt_width_i is 3, or when tgt_width_i is 2 (32-bit) while bus_mode_i is not 2'b01. In the cycle after acceptance, an illegal request produces req_ready_o=1 and req_err_o=1 with ext_valid_o=0, and it never raises ext_valid_o.
- R2: With sizes coded 0=byte, 1=halfword, 2=word and target widths coded 0=8, 1=16, 2=32 bits, a legal access makes N = access_bytes / min(access_bytes, target_bytes) transfers. ext_valid_o rises in the cycle after acceptance and stays high until the N-th transfer has been given ext_ready_i. req_ready_o stays low during this time.
- R3: Let S = min(access_bytes, target_bytes). Transfer k presents ext_addr_o = A + k*S, where A is req_addr_i rounded down to a multiple of access_bytes.
- R4: In little-endian mode (big_endian_i=0), for each memory byte b covered by a write transfer, ext_wdata_o lane (b mod target_bytes) carries req_wdata_i lane b. All other lanes are zero, and all lanes are zero on reads.
- R5: In big-endian mode, the rule of R4 takes the byte from internal lane 3-b instead of b. The same mirroring applies on reads.
- R6: ext_wstrb_no is active low per lane. It is 0 exactly on the lanes driven by a write transfer, and it is all ones on read transfers and whenever ext_valid_o is low.
- R7: While ext_valid_o=1 and ext_ready_i=0, the transfer does not advance. ext_addr_o, ext_wdata_o and ext_wstrb_no hold their values, and ext_rdata_i is ignored.
- R8: One cycle after the last transfer's ready, req_ready_o pulses for one cycle with req_err_o=0. For a read, req_rdata_o then holds each covered internal lane filled from the external lane of R4/R5 as sampled on that transfer's ready cycle, with uncovered lanes zero. For a write, req_rdata_o is zero, and it is also zero after an error completion.
- R9: req_valid_i is sampled only when the block is idle. A request raised during a transfer or a completion cycle has no effect on the outputs.
- R10: During reset, ext_valid_o=0, req_ready_o=0, req_err_o=0 and ext_wstrb_no is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | 1 selects big-endian lane numbering |
| bus_mode_i | input | 2 | 2'b01 full-width external bus, otherwise half width |
| tgt_width_i | input | 2 | Target width: 0=8, 1=16, 2=32 bits, 3 reserved |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr_i | input | 2 | Byte offset within the word |
| req_wdata_i | input | 32 | Internal write data |
| req_ready_o | output | 1 | Completion pulse |
| req_err_o | output | 1 | Completion was an illegal configuration |
| req_rdata_o | output | 32 | Assembled read data, valid with req_ready_o |
| ext_valid_o | output | 1 | External transfer presented |
| ext_ready_i | input | 1 | External transfer accepted |
| ext_addr_o | output | 2 | Byte offset of the current transfer |
| ext_wdata_o | output | 32 | External write lanes |
| ext_wstrb_no | output | 4 | Per-lane write strobes, active low |
| ext_rdata_i | input | 32 | External read lanes |

## Verification
A wrong transfer counter shows at once on ext_addr_o. It also shows as a transfer count that is off by one or more, where ext_valid_o drops early or req_ready_o arrives late. A wrong lane or endian mapping shows up as a misplaced byte on ext_wdata_o or ext_wstrb_no in the same cycle the transfer is presented. On reads it shows up as a misplaced byte in req_rdata_o at the completion pulse. A latched request that is corrupted by traffic while busy changes the very next presented transfer. The reference model compares every port on every cycle, including stall cycles in which ext_rdata_i carries junk, so each of these faults is caught within the cycle in which it first appears.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} bsz_state_e;

  function automatic logic [1:0] min_log(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / 8,
  localparam int unsigned AW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        tgt_width_i,
  input  logic [1:0]        bus_mode_i,
  input  logic              big_endian_i,
  input  logic              ext_ready_i,
  output bsz_state_e        state_o,
  output logic [AW-1:0]     cnt_o,
  output logic              r_write_o,
  output logic [1:0]        r_size_o,
  output logic [AW-1:0]     r_addr_o,
  output logic [DATA_W-1:0] r_wdata_o,
  output logic [1:0]        r_tw_o,
  output logic              r_be_o,
  output logic              r_err_o,
  output logic              accept_o,
  output logic              capture_o
);
  localparam logic [1:0] MAX_LOG = 2'(AW);

  bsz_state_e        state_q;
  logic [AW-1:0]     cnt_q;
  logic              write_q, be_q, err_q;
  logic [1:0]        size_q, tw_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [1:0] max_tw, step_log, n_log;
  logic [AW:0] n_xfer;
  logic bad_cfg, last;

  assign max_tw   = (bus_mode_i == 2'b01) ? MAX_LOG : MAX_LOG - 2'd1;
  assign bad_cfg  = (req_size_i > MAX_LOG) || (tgt_width_i > max_tw);
  assign accept_o = (state_q == ST_IDLE) && req_valid_i;

  assign step_log = min_log(size_q, tw_q);
  assign n_log    = size_q - step_log;
  assign n_xfer   = (AW+1)'(1) << n_log;
  assign last     = (({1'b0, cnt_q} + (AW+1)'(1)) == n_xfer);
  assign capture_o = (state_q == ST_XFER) && ext_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      write_q <= 1'b0;
      be_q    <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= '0;
      tw_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          write_q <= req_write_i;
          be_q    <= big_endian_i;
          size_q  <= req_size_i;
          tw_q    <= tgt_width_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          err_q   <= bad_cfg;
          cnt_q   <= '0;
          state_q <= bad_cfg ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (ext_ready_i) begin
          if (last) state_q <= ST_DONE;
          else      cnt_q   <= cnt_q + AW'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign r_write_o = write_q;
  assign r_size_o  = size_q;
  assign r_addr_o  = addr_q;
  assign r_wdata_o = wdata_q;
  assign r_tw_o    = tw_q;
  assign r_be_o    = be_q;
  assign r_err_o   = err_q;
endmodule

// File: rtl/bsz_lane_map.sv
module bsz_lane_map
  import bsz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / 8,
  localparam int unsigned AW = $clog2(NB)
) (
  input  logic                  active_i,
  input  logic                  write_i,
  input  logic                  be_i,
  input  logic [1:0]            size_i,
  input  logic [1:0]            tw_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [AW-1:0]         cnt_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [AW-1:0]         ext_addr_o,
  output logic [DATA_W-1:0]     ext_wdata_o,
  output logic [NB-1:0]         ext_wstrb_no,
  output logic [NB-1:0]         hit_o,
  output logic [NB-1:0][AW-1:0] src_o
);
  logic [1:0]    step_log;
  logic [AW:0]   acc_n, tgt_n, step_n;
  logic [AW-1:0] start, tmask, base;

  assign step_log = min_log(size_i, tw_i);
  assign acc_n    = (AW+1)'(1) << size_i;
  assign tgt_n    = (AW+1)'(1) << tw_i;
  assign step_n   = (AW+1)'(1) << step_log;
  assign start    = addr_i & ~(acc_n[AW-1:0] - AW'(1));
  assign tmask    = tgt_n[AW-1:0] - AW'(1);
  assign base     = start + (cnt_i << step_log);

  always_comb begin
    logic [AW-1:0] b, el, il;
    ext_wdata_o  = '0;
    ext_wstrb_no = '1;
    hit_o        = '0;
    src_o        = '0;
    ext_addr_o   = active_i ? base : '0;
    for (int j = 0; j < NB; j++) begin
      b  = base + AW'(j);
      el = b & tmask;
      il = be_i ? ~b : b;  // big-endian mirrors lane index
      if (active_i && ((AW+1)'(j) < step_n)) begin
        hit_o[il] = 1'b1;
        src_o[il] = el;
        if (write_i) begin
          ext_wdata_o[int'(el)*8 +: 8] = wdata_i[int'(il)*8 +: 8];
          ext_wstrb_no[el] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bsz_rd_asm.sv
module bsz_rd_asm #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / 8,
  localparam int unsigned AW = $clog2(NB)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  capture_i,
  input  logic [NB-1:0]         hit_i,
  input  logic [NB-1:0][AW-1:0] src_i,
  input  logic [DATA_W-1:0]     ext_rdata_i,
  output logic [DATA_W-1:0]     rdata_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   lane_q <= '0;
      else if (clear_i)              lane_q <= '0;
      else if (capture_i && hit_i[i]) lane_q <= ext_rdata_i[int'(src_i[i])*8 +: 8];
    end
    assign rdata_o[i*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / 8,
  localparam int unsigned AW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic [1:0]        bus_mode_i,
  input  logic [1:0]        tgt_width_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              req_err_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              ext_valid_o,
  input  logic              ext_ready_i,
  output logic [AW-1:0]     ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic [NB-1:0]     ext_wstrb_no,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  bsz_state_e        state;
  logic [AW-1:0]     cnt, r_addr;
  logic              r_write, r_be, r_err, accept, capture;
  logic [1:0]        r_size, r_tw;
  logic [DATA_W-1:0] r_wdata;
  logic [NB-1:0]     hit;
  logic [NB-1:0][AW-1:0] src;

  bsz_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_size_i, .req_addr_i,
    .req_wdata_i, .tgt_width_i, .bus_mode_i, .big_endian_i, .ext_ready_i,
    .state_o(state), .cnt_o(cnt), .r_write_o(r_write), .r_size_o(r_size),
    .r_addr_o(r_addr), .r_wdata_o(r_wdata), .r_tw_o(r_tw), .r_be_o(r_be),
    .r_err_o(r_err), .accept_o(accept), .capture_o(capture)
  );

  assign ext_valid_o = (state == ST_XFER);
  assign req_ready_o = (state == ST_DONE);
  assign req_err_o   = req_ready_o && r_err;

  bsz_lane_map #(.DATA_W(DATA_W)) u_map (
    .active_i(ext_valid_o), .write_i(r_write), .be_i(r_be), .size_i(r_size),
    .tw_i(r_tw), .addr_i(r_addr), .cnt_i(cnt), .wdata_i(r_wdata),
    .ext_addr_o, .ext_wdata_o, .ext_wstrb_no, .hit_o(hit), .src_o(src)
  );

  bsz_rd_asm #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .clear_i(accept), .capture_i(capture && !r_write),
    .hit_i(hit), .src_i(src), .ext_rdata_i, .rdata_o(req_rdata_o)
  );
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / 8,
  localparam int unsigned AW = $clog2(NB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        bus_mode_i,
  input logic [1:0]        tgt_width_i,
  input logic              req_valid_i,
  input logic [1:0]        req_size_i,
  input logic              req_ready_o,
  input logic              req_err_o,
  input logic              ext_valid_o,
  input logic              ext_ready_i,
  input logic [AW-1:0]     ext_addr_o,
  input logic [DATA_W-1:0] ext_wdata_o,
  input logic [NB-1:0]     ext_wstrb_no
);
  logic idle, bad;
  assign idle = !ext_valid_o && !req_ready_o;
  assign bad  = (req_size_i == 2'd3) || (tgt_width_i == 2'd3) ||
                ((tgt_width_i == 2'd2) && (bus_mode_i != 2'b01));

  AST_BAD_CFG_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && req_valid_i && bad) |=> (req_ready_o && req_err_o && !ext_valid_o)); // R1
  AST_ERR_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_err_o) |-> !$past(ext_valid_o)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !ext_ready_i) |=> (ext_valid_o && $stable(ext_addr_o) &&
      $stable(ext_wdata_o) && $stable(ext_wstrb_no))); // R7
  AST_IDLE_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_valid_o |-> (&ext_wstrb_no)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_err_o) |-> $past(ext_valid_o && ext_ready_i)); // R2
  AST_NARROW_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && bus_mode_i != 2'b01) |-> (ext_wdata_o[DATA_W-1:DATA_W/2] == '0)); // R4
endmodule

bind bus_sizer bus_sizer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_mode_i(bus_mode_i), .tgt_width_i(tgt_width_i),
  .req_valid_i(req_valid_i), .req_size_i(req_size_i), .req_ready_o(req_ready_o),
  .req_err_o(req_err_o), .ext_valid_o(ext_valid_o), .ext_ready_i(ext_ready_i),
  .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o), .ext_wstrb_no(ext_wstrb_no)
);

// File: tb/bus_sizer_test.sv
module bus_sizer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic big_endian = 1'b0, req_valid = 1'b0, req_write = 1'b0, ext_ready = 1'b0;
  logic [1:0] bus_mode = 2'b01, tgt_width = 2'd0, req_size = 2'd0, req_addr = 2'd0;
  logic [31:0] req_wdata = '0, ext_rdata = '0;
  logic req_ready, req_err, ext_valid;
  logic [31:0] req_rdata, ext_wdata;
  logic [1:0] ext_addr;
  logic [3:0] ext_wstrb_n;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] rng = 32'h2545_f491;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sizer uut (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian), .bus_mode_i(bus_mode),
    .tgt_width_i(tgt_width), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .req_err_o(req_err), .req_rdata_o(req_rdata),
    .ext_valid_o(ext_valid), .ext_ready_i(ext_ready), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .ext_wstrb_no(ext_wstrb_n), .ext_rdata_i(ext_rdata)
  );

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic run_req(input bit w, input int sz, input int ad, input int tw,
                         input bit be, input logic [1:0] bm, input logic [31:0] wd);
    int acc, tb, step, n, start, base, b, el, il, maxtw;
    bit bad, rdy, spur, spur_prev;
    logic [31:0] exp_wd, exp_rd, rd;
    logic [3:0] exp_st;
    string tag;
    big_endian = be; bus_mode = bm;
    req_write = w; req_size = 2'(sz); req_addr = 2'(ad); tgt_width = 2'(tw);
    req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    maxtw = (bm == 2'b01) ? 2 : 1;
    bad = (sz > 2) || (tw > maxtw);
    if (bad) begin
      chk("R1 ready", 32'(req_ready), 1);
      chk("R1 err", 32'(req_err), 1);
      chk("R1 no xfer", 32'(ext_valid), 0);
      chk("R8 rdata after err", req_rdata, 0);
      @(posedge clk); @(negedge clk);
      chk("R1 idle after err", 32'(ext_valid | req_ready), 0);
      return;
    end
    acc = 1 << sz; tb = 1 << tw; step = (acc < tb) ? acc : tb;
    n = acc / step; start = ad & ~(acc - 1); exp_rd = '0; spur_prev = 1'b0;
    for (int k = 0; k < n; k++) begin
      base = start + k * step;
      exp_wd = '0; exp_st = 4'hf;
      if (w) for (int j = 0; j < step; j++) begin
        b = base + j; el = b % tb; il = be ? 3 - b : b;
        exp_wd[el*8 +: 8] = wd[il*8 +: 8];
        exp_st[el] = 1'b0;
      end
      forever begin
        tag = spur_prev ? "R9" : (be ? "R5" : "R4");
        chk("R2 valid", 32'(ext_valid), 1);
        chk("R2 not done", 32'(req_ready), 0);
        chk(spur_prev ? "R9 addr" : "R3 addr", 32'(ext_addr), 32'(base));
        chk({tag, " wdata"}, ext_wdata, exp_wd);
        chk(spur_prev ? "R9 strb" : "R6 strb", 32'(ext_wstrb_n), 32'(exp_st));
        rdy = (next_rand() % 3) != 0;
        rd = next_rand();
        ext_rdata = rd; ext_ready = rdy;
        spur = !rdy && next_rand()[0];
        if (spur) begin
          req_valid = 1'b1; req_write = ~w; req_size = 2'd2;
          req_addr = 2'(ad + 1); req_wdata = ~wd; tgt_width = 2'd0;
        end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; ext_ready = 1'b0; ext_rdata = next_rand();
        spur_prev = spur;
        if (rdy) begin
          for (int j = 0; j < step; j++) begin
            b = base + j; el = b % tb; il = be ? 3 - b : b;
            exp_rd[il*8 +: 8] = rd[el*8 +: 8];
          end
          break;
        end
        chk("R7 held", 32'(ext_valid), 1);
      end
    end
    chk("R8 ready", 32'(req_ready), 1);
    chk("R8 err low", 32'(req_err), 0);
    chk(be ? "R8 R5 rdata" : "R8 rdata", req_rdata, w ? 32'h0 : exp_rd);
    chk("R2 valid low at done", 32'(ext_valid), 0);
    chk("R6 strb at done", 32'(ext_wstrb_n), 32'hf);
    req_valid = 1'b1; req_size = 2'd3;  // ignored during completion
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R8 pulse", 32'(req_ready), 0);
    chk("R9 no start", 32'(ext_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 valid", 32'(ext_valid), 0);
    chk("R10 ready", 32'(req_ready), 0);
    chk("R10 err", 32'(req_err), 0);
    chk("R10 strb", 32'(ext_wstrb_n), 32'hf);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner: word to 8-bit target, big endian
    run_req(1'b1, 2, 0, 0, 1'b1, 2'b01, 32'hA1B2_C3D4);
    run_req(1'b0, 1, 3, 1, 1'b0, 2'b00, 32'h0);
    // illegal cases
    run_req(1'b1, 2, 0, 2, 1'b0, 2'b00, 32'h1111_2222);
    run_req(1'b0, 2, 0, 2, 1'b1, 2'b10, 32'h0);
    run_req(1'b1, 1, 0, 3, 1'b0, 2'b01, 32'h0);
    run_req(1'b0, 3, 0, 0, 1'b0, 2'b01, 32'h0);
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int wr = 0; wr < 2; wr++)
          for (int s = 0; s < 3; s++)
            for (int t = 0; t < 3; t++)
              for (int a = 0; a < 4; a++)
                run_req(wr[0], s, a, t, e[0], (m == 0) ? 2'b01 : 2'b00, next_rand());
    finish_run();
  end
endmodule